// File: doc/BRIEF.md
# Two-Phase Interleaved Gate PWM Generator

This block turns a duty-cycle count into two gate signals for a two-phase interleaved boost stage. A free-running counter sets the switching period: at 1667 counts on a 50 MHz clock it switches at about 30 kHz. The main gate is high for the first `duty` counts of each period and drives both switches of the main pair. A second counter runs one eighth of a period (208 counts) behind the first and produces the auxiliary gate. That gate has the same high time, shifted by 45 degrees of the period.

The duty command may change at any time. The main phase takes the new value only at the start of one of its own periods, and the auxiliary phase only at the start of one of its own periods. A pulse that has begun therefore always runs to its full width, and the switching frequency never changes. When the enable is low, both gates stay low and both counters wait at their start points. The counters restart cleanly when the enable returns. Dead time, drivers and the voltage loop sit outside this block.

Top module: `ilv_dpwm`

## Requirements
- R1: While enabled, the main gate rises at intervals of exactly PERIOD clock cycles (1667 by default), whatever the duty command.
- R2: With a duty count D where 0 < D < PERIOD, the main gate is high for exactly D consecutive cycles in each period.
- R3: The auxiliary gate has the same width as the main gate and rises exactly SHIFT cycles (208 by default) after the main gate in each period.
- R4: A duty change that arrives while a main pulse is running does not alter that pulse. The main phase takes the duty input sampled on the last cycle of its period, and uses it for the following period.
- R5: The auxiliary phase takes the duty input sampled on the last cycle of its own period, which ends SHIFT cycles after the main period ends. It can therefore pick up a change that the running main period did not.
- R6: A duty count of 0 keeps both gates low.
- R7: A duty count equal to or above PERIOD keeps both gates high for the whole period.
- R8: In reset, or with `en` low, both gates are low one clock edge after it is seen. The main counter waits at 0 and the auxiliary counter waits at PERIOD-SHIFT. While `en` is low, the duty input is sampled on every cycle. On the first edge with `en` high, the main gate goes high if that sampled duty is non-zero. The auxiliary gate stays low for the first SHIFT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables switching; low forces both gates off |
| duty | input | DW (11) | Duty count: the number of high cycles per period |
| gate_main | output | 1 | Registered gate for the main switch pair |
| gate_aux | output | 1 | Registered gate for the auxiliary pair, delayed by SHIFT cycles |

## Verification
The bench changes the duty in the middle of a running pulse, and between the start of the main pulse and the start of the auxiliary pulse. A design that latched the duty continuously would cut the running main pulse short. A design that shared one latch between the two phases would give the auxiliary pulse the old width. Zero duty and over-range duty are held for whole periods: an off-by-one compare would leave a one-cycle sliver or a one-cycle gap. Toggling the enable checks that both counters restart, and that no stale auxiliary pulse appears before the first delayed one.

// File: rtl/ilv_dpwm.sv
module ilv_dpwm #(
  parameter int PERIOD = 1667,
  parameter int SHIFT  = 208,
  parameter int DW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] duty,
  output logic          gate_main,
  output logic          gate_aux
);
  localparam int CW = $clog2(PERIOD);
  localparam int XW = (DW > CW) ? DW : CW;
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] A_START = CW'(PERIOD - SHIFT);

  logic [CW-1:0] ramp_m, ramp_a;
  logic [DW-1:0] duty_m, duty_a;
  logic m_wrap, a_wrap, m_on, a_on;

  assign m_wrap = (ramp_m == LAST);
  assign a_wrap = (ramp_a == LAST);
  assign m_on   = XW'(ramp_m) < XW'(duty_m);
  assign a_on   = XW'(ramp_a) < XW'(duty_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_m    <= '0;
      ramp_a    <= A_START;
      duty_m    <= '0;
      duty_a    <= '0;
      gate_main <= 1'b0;
      gate_aux  <= 1'b0;
    end else if (!en) begin
      ramp_m    <= '0;
      ramp_a    <= A_START;
      duty_m    <= duty;
      duty_a    <= '0;
      gate_main <= 1'b0;
      gate_aux  <= 1'b0;
    end else begin
      ramp_m    <= m_wrap ? '0 : ramp_m + 1'b1;
      ramp_a    <= a_wrap ? '0 : ramp_a + 1'b1;
      if (m_wrap) duty_m <= duty;
      if (a_wrap) duty_a <= duty;
      gate_main <= m_on;
      gate_aux  <= a_on;
    end
  end
endmodule

// File: rtl/ilv_dpwm_chk.sv
module ilv_dpwm_chk #(
  parameter int PERIOD = 1667,
  parameter int SHIFT  = 208,
  parameter int DW     = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [DW-1:0] duty,
  input logic          gate_main,
  input logic          gate_aux
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam int HW = $clog2(2 * PERIOD + 2);
  localparam logic [HW-1:0] HOLD = HW'(2 * PERIOD);

  logic [PW-1:0] since_rise;
  logic          seen, gm_q;
  logic [HW-1:0] zero_cnt, full_cnt;
  logic          rise;

  assign rise = gate_main && !gm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rise <= '0;
      seen       <= 1'b0;
      gm_q       <= 1'b0;
      zero_cnt   <= '0;
      full_cnt   <= '0;
    end else begin
      gm_q <= gate_main;
      if (!en) begin
        seen       <= 1'b0;
        since_rise <= '0;
      end else if (rise) begin
        seen       <= 1'b1;
        since_rise <= PW'(1);
      end else begin
        since_rise <= (since_rise == PW'(PERIOD - 1)) ? '0 : since_rise + 1'b1;
      end
      if (duty != '0) zero_cnt <= '0;
      else if (zero_cnt != HOLD) zero_cnt <= zero_cnt + 1'b1;
      if (!en || (int'(duty) < PERIOD)) full_cnt <= '0;
      else if (full_cnt != HOLD) full_cnt <= full_cnt + 1'b1;
    end
  end

  // R1
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise && seen |-> since_rise == '0);

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_main && !gate_aux);

  // R8
  gate_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_main || gate_aux) |-> $past(en));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cnt == HOLD |-> !gate_main && !gate_aux);

  // R7
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_cnt == HOLD |-> gate_main && gate_aux);
endmodule

bind ilv_dpwm ilv_dpwm_chk #(.PERIOD(PERIOD), .SHIFT(SHIFT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
  .gate_main(gate_main), .gate_aux(gate_aux)
);

// File: tb/ilv_dpwm_tb_top.sv
module ilv_dpwm_tb_top;
  localparam int P  = 1667;
  localparam int S  = 208;
  localparam int DW = 11;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [DW-1:0] duty = '0;
  logic gm, ga;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ilv_dpwm #(.PERIOD(P), .SHIFT(S), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .duty(duty),
    .gate_main(gm), .gate_aux(ga)
  );

  // reference from the requirements: e counts enabled edges
  int e, dm, da;
  bit exm, exa;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e <= 0; dm <= 0; da <= 0; exm <= 1'b0; exa <= 1'b0;
    end else if (!en) begin
      e <= 0; dm <= int'(duty); da <= 0; exm <= 1'b0; exa <= 1'b0;
    end else begin
      e   <= e + 1;
      exm <= (e % P) < dm;
      if (e % P == P - 1) dm <= int'(duty);
      exa <= (e >= S) ? (((e - S) % P) < da) : 1'b0;
      if ((e + 1 >= S) && ((e + 1 - S) % P == 0)) da <= int'(duty);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int idx = 0, hm = 0, ha = 0, mr_prev = -1, mr_last = -1, ar_last = -1;
  bit pm = 1'b0, pa = 1'b0;

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("R2/R3/R5 model main", int'(gm), int'(exm));
      chk("R2/R3/R5 model aux", int'(ga), int'(exa));
      if (gm) hm++;
      if (ga) ha++;
      if (gm && !pm) begin mr_prev = mr_last; mr_last = idx; end
      if (ga && !pa) ar_last = idx;
      pm = gm; pa = ga;
      idx++;
    end
  endtask

  task automatic clr();
    hm = 0; ha = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset main", int'(gm), 0);
    chk("R8 reset aux", int'(ga), 0);
    rst_n = 1'b1;
    duty  = DW'(500);
    step(3);
    chk("R8 idle main", int'(gm), 0);

    en = 1'b1; idx = 0; clr();
    step(P);
    chk("R2 width", hm, 500);
    chk("R8 first main rise", mr_last, 0);
    chk("R3 aux delay", ar_last - mr_last, S);
    step(P);
    chk("R1 period", mr_last - mr_prev, P);

    step(100);
    duty = DW'(100); clr();
    step(P - 100);
    chk("R4 running pulse kept", hm, 400);
    chk("R5 aux takes new duty", ha, 100);
    clr();
    step(P);
    chk("R4 next period width", hm, 100);
    chk("R3 aux width", ha, 100);

    duty = '0;
    step(2 * P); clr();
    step(P);
    chk("R6 zero main", hm, 0);
    chk("R6 zero aux", ha, 0);

    duty = DW'(2047);
    step(2 * P); clr();
    step(P);
    chk("R7 full main", hm, P);
    chk("R7 full aux", ha, P);

    en = 1'b0;
    step(1);
    chk("R8 disable main", int'(gm), 0);
    chk("R8 disable aux", int'(ga), 0);
    step(5);
    duty = DW'(300);
    step(1);
    en = 1'b1; idx = 0; clr(); mr_last = -1; ar_last = -1;
    step(P);
    chk("R8 restart width", hm, 300);
    chk("R8 restart main rise", mr_last, 0);
    chk("R8 restart aux rise", ar_last, S);

    repeat (40) begin
      step(200 + int'($urandom % 800));
      duty = DW'($urandom % 1800);
      if ($urandom % 10 == 0) begin
        en = 1'b0;
        step(3);
        en = 1'b1;
      end
    end
    step(P);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule